// File: doc/BRIEF.md
# Combined Timer Event Interrupt Bank

This block gathers the event pulses of five timer channels and one timer-overflow source into a single combined event line for a chip-level event fabric. Each source owns one bit of a raw status register. A mask register selects which raw bits reach the combined line, and the masked status is the product of the two. Software writes go through a small command port. The port takes a two-bit operation code and a data word, and each 1 in the data word sets or clears the matching bit of the raw status or of the mask.

Each channel also has an auto-clear strobe. The channel logic raises it when a capture value is read, a compare value is written or the channel is armed, and the strobe drops that channel's raw bit without any software write. Each channel's pulse is also forwarded one cycle later on its own event output. An overflow pulse starts a hold window whose length is a fixed number of seconds at the configured clock rate, and the overflow indication stays high for that whole window.

Top module: `evt_combiner`

## Requirements
- R1: After reset the raw status, mask, masked status, combined line, overflow indication and per-channel outputs are all 0.
- R2: A pulse on channel event input i sets raw bit i on the next clock edge. An overflow pulse sets raw bit 5, the bit just above the channels.
- R3: A write with operation code 1 (status-clear) clears every raw bit whose data bit is 1 and leaves the other raw bits unchanged.
- R4: A pulse on channel i's auto-clear strobe clears raw bit i and no other bit.
- R5: When a set from an event pulse or a status-set write and a clear from a strobe or a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A write with operation code 0 (status-set) sets every raw bit whose data bit is 1.
- R7: A write with operation code 2 (mask-set) sets the mask bits whose data bit is 1, and operation code 3 (mask-clear) clears them. Mask bits written with 0 keep their value.
- R8: The masked status output equals raw status AND mask.
- R9: The combined event output is high exactly when at least one masked status bit is 1.
- R10: An overflow pulse raises the overflow indication for exactly CLK_HZ*HOLD_SEC cycles. A new pulse during the window restarts the full window.
- R11: Each per-channel event output repeats its channel's event input one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| chan_evt_i | input | NCH | Per-channel event pulses |
| chan_autoclr_i | input | NCH | Per-channel raw-status auto-clear strobes |
| ovf_evt_i | input | 1 | Timer overflow pulse |
| wr_en_i | input | 1 | Command write strobe |
| wr_op_i | input | 2 | Operation: 0 status-set, 1 status-clear, 2 mask-set, 3 mask-clear |
| wr_data_i | input | NCH+1 | Bit vector the operation applies to |
| raw_o | output | NCH+1 | Raw status register |
| mask_o | output | NCH+1 | Mask register |
| masked_o | output | NCH+1 | Raw status AND mask |
| comb_evt_o | output | 1 | Combined event line |
| chan_evt_o | output | NCH | Registered per-channel event outputs |
| ovf_active_o | output | 1 | Overflow indication held for the hold window |

## Verification
The assertions check, on every cycle, that an event pulse always leaves its raw bit set and that a lone auto-clear strobe always leaves it clear. They also check that the mask does not move without a write, that an all-zero mask keeps the combined line low, that the overflow indication only rises after an overflow pulse, and that the channel outputs trail their inputs by one cycle. Only the bench scenarios show the exact bit patterns. These cover partial status-clear and mask writes that leave neighbouring bits alone, the set-over-clear outcome when software and hardware collide, and the exact length of the overflow window and its restart.

// File: rtl/evt_combiner_pkg.sv
package evt_combiner_pkg;
  typedef enum logic [1:0] {
    OP_STS_SET = 2'd0,
    OP_STS_CLR = 2'd1,
    OP_MSK_SET = 2'd2,
    OP_MSK_CLR = 2'd3
  } wr_op_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/evt_ovf_hold.sv
module evt_ovf_hold #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    if (trig_i) cnt_d = CW'(HOLD_CYC);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/evt_bit_bank.sv
module evt_bit_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         upd_en;

  always_comb begin
    q_d    = (q_o & ~clr_i) | set_i;
    upd_en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (upd_en) q_o <= q_d;
  end
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
  import evt_combiner_pkg::*;
#(
  parameter int unsigned NCH      = 5,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned HOLD_SEC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_evt_i,
  input  logic [NCH-1:0] chan_autoclr_i,
  input  logic           ovf_evt_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_op_i,
  input  logic [NCH:0]   wr_data_i,
  output logic [NCH:0]   raw_o,
  output logic [NCH:0]   mask_o,
  output logic [NCH:0]   masked_o,
  output logic           comb_evt_o,
  output logic [NCH-1:0] chan_evt_o,
  output logic           ovf_active_o
);
  localparam int unsigned NSRC     = NCH + 1;
  localparam int unsigned HOLD_CYC = CLK_HZ * HOLD_SEC;

  logic            rst_sync_n;
  logic [NSRC-1:0] sts_set, sts_clr, msk_set, msk_clr;
  logic [NSRC-1:0] hw_set, hw_clr;
  logic [NCH-1:0]  chan_q;

  evt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sts_set = '0;
    sts_clr = '0;
    msk_set = '0;
    msk_clr = '0;
    if (wr_en_i) begin
      unique case (wr_op_e'(wr_op_i))
        OP_STS_SET: sts_set = wr_data_i;
        OP_STS_CLR: sts_clr = wr_data_i;
        OP_MSK_SET: msk_set = wr_data_i;
        OP_MSK_CLR: msk_clr = wr_data_i;
        default:    ;
      endcase
    end
  end

  // Hardware sources: one bit per channel, overflow on the top bit.
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_src
      assign hw_set[i] = chan_evt_i[i];
      assign hw_clr[i] = chan_autoclr_i[i];
    end
  endgenerate
  assign hw_set[NCH] = ovf_evt_i;
  assign hw_clr[NCH] = 1'b0;

  evt_bit_bank #(.W(NSRC)) u_raw (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (hw_set | sts_set),
    .clr_i (hw_clr | sts_clr),
    .q_o   (raw_o)
  );

  evt_bit_bank #(.W(NSRC)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (msk_set),
    .clr_i (msk_clr),
    .q_o   (mask_o)
  );

  evt_ovf_hold #(.HOLD_CYC(HOLD_CYC)) u_ovf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_i   (ovf_evt_i),
    .active_o (ovf_active_o)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chan_q <= '0;
    else             chan_q <= chan_evt_i;
  end

  assign chan_evt_o = chan_q;
  assign masked_o   = raw_o & mask_o;
  assign comb_evt_o = |masked_o;
endmodule

// File: rtl/evt_combiner_chk.sv
module evt_combiner_chk #(
  parameter int unsigned NCH = 5
) (
  input logic           clk,
  input logic           rst_ni,
  input logic [NCH-1:0] chan_evt_i,
  input logic [NCH-1:0] chan_autoclr_i,
  input logic           ovf_evt_i,
  input logic           wr_en_i,
  input logic [1:0]     wr_op_i,
  input logic [NCH:0]   wr_data_i,
  input logic [NCH:0]   raw_o,
  input logic [NCH:0]   mask_o,
  input logic           comb_evt_o,
  input logic [NCH-1:0] chan_evt_o,
  input logic           ovf_active_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_ni)
        chan_evt_i[i] |=> raw_o[i]); // R2
      AST_AUTOCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_ni)
        (chan_autoclr_i[i] && !chan_evt_i[i] &&
         !(wr_en_i && wr_op_i == 2'd0 && wr_data_i[i])) |=> !raw_o[i]); // R4
    end
  endgenerate

  AST_OVF_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_evt_i |=> raw_o[NCH]); // R2
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_o)); // R7
  AST_COMB_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (mask_o == '0) |-> !comb_evt_o); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (past_ok && $rose(ovf_active_o)) |-> $past(ovf_evt_i)); // R10
  AST_CHAN_DELAY: assert property (@(posedge clk) disable iff (!rst_ni)
    past_ok |-> (chan_evt_o == $past(chan_evt_i))); // R11
endmodule

bind evt_combiner evt_combiner_chk #(.NCH(NCH)) u_chk (
  .clk            (clk),
  .rst_ni         (rst_sync_n),
  .chan_evt_i     (chan_evt_i),
  .chan_autoclr_i (chan_autoclr_i),
  .ovf_evt_i      (ovf_evt_i),
  .wr_en_i        (wr_en_i),
  .wr_op_i        (wr_op_i),
  .wr_data_i      (wr_data_i),
  .raw_o          (raw_o),
  .mask_o         (mask_o),
  .comb_evt_o     (comb_evt_o),
  .chan_evt_o     (chan_evt_o),
  .ovf_active_o   (ovf_active_o)
);

// File: tb/evt_combiner_bench.sv
module evt_combiner_bench;
  localparam int unsigned NCH  = 5;
  localparam int unsigned HOLD = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] chan_evt_i, chan_autoclr_i;
  logic           ovf_evt_i, wr_en_i;
  logic [1:0]     wr_op_i;
  logic [NCH:0]   wr_data_i;
  logic [NCH:0]   raw_o, mask_o, masked_o;
  logic           comb_evt_o, ovf_active_o;
  logic [NCH-1:0] chan_evt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  evt_combiner #(.NCH(NCH), .CLK_HZ(4), .HOLD_SEC(2)) u_evt_combiner (
    .clk(clk), .rst_n(rst_n), .chan_evt_i(chan_evt_i),
    .chan_autoclr_i(chan_autoclr_i), .ovf_evt_i(ovf_evt_i),
    .wr_en_i(wr_en_i), .wr_op_i(wr_op_i), .wr_data_i(wr_data_i),
    .raw_o(raw_o), .mask_o(mask_o), .masked_o(masked_o),
    .comb_evt_o(comb_evt_o), .chan_evt_o(chan_evt_o),
    .ovf_active_o(ovf_active_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    chan_evt_i = '0; chan_autoclr_i = '0; ovf_evt_i = 1'b0;
    wr_en_i = 1'b0; wr_op_i = 2'd0; wr_data_i = '0;
  endtask

  // Inputs are driven after a falling edge and held for one rising edge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [1:0] op, logic [NCH:0] d);
    wr_en_i = 1'b1; wr_op_i = op; wr_data_i = d;
    step();
  endtask

  task automatic t_reset();
    chk("R1 raw", 32'(raw_o), 0);
    chk("R1 mask", 32'(mask_o), 0);
    chk("R1 comb", 32'(comb_evt_o), 0);
    chk("R1 ovf", 32'(ovf_active_o), 0);
    chk("R1 chan_out", 32'(chan_evt_o), 0);
  endtask

  task automatic t_events();
    chan_evt_i = 5'b00101; step();
    chk("R2 raw after ch0,ch2", 32'(raw_o), 32'h05);
    chan_evt_i = 5'b10000; step();
    chk("R2 raw after ch4", 32'(raw_o), 32'h15);
  endtask

  task automatic t_sw_clear();
    wr(2'd1, 6'b000100);
    chk("R3 partial clear", 32'(raw_o), 32'h11);
    wr(2'd1, 6'b111111);
    chk("R3 full clear", 32'(raw_o), 32'h00);
  endtask

  task automatic t_sw_set();
    wr(2'd0, 6'b101010);
    chk("R6 status set", 32'(raw_o), 32'h2A);
  endtask

  task automatic t_autoclr();
    chan_autoclr_i = 5'b00010; step();
    chk("R4 autoclr ch1 only", 32'(raw_o), 32'h28);
  endtask

  task automatic t_set_wins();
    chan_evt_i = 5'b00001; chan_autoclr_i = 5'b00001; step();
    chk("R5 event vs strobe", 32'(raw_o), 32'h29);
    chan_autoclr_i = 5'b01000;
    wr_en_i = 1'b1; wr_op_i = 2'd0; wr_data_i = 6'b001000; step();
    chk("R5 sw set vs strobe", 32'(raw_o), 32'h29);
    chan_evt_i = 5'b00001;
    wr_en_i = 1'b1; wr_op_i = 2'd1; wr_data_i = 6'b000001; step();
    chk("R5 event vs sw clear", 32'(raw_o), 32'h29);
  endtask

  task automatic t_mask();
    wr(2'd2, 6'b000011);
    chk("R7 mask set", 32'(mask_o), 32'h03);
    wr(2'd2, 6'b100000);
    chk("R7 mask set keeps others", 32'(mask_o), 32'h23);
    wr(2'd3, 6'b000001);
    chk("R7 mask clear", 32'(mask_o), 32'h22);
    chk("R8 masked", 32'(masked_o), 32'h20);
    chk("R9 comb high", 32'(comb_evt_o), 1);
    wr(2'd3, 6'b100000);
    chk("R8 masked none", 32'(masked_o), 32'h00);
    chk("R9 comb low with raw set", 32'(comb_evt_o), 0);
    wr(2'd2, 6'b000010);
    chan_evt_i = 5'b00010; step();
    chk("R8 masked ch1", 32'(masked_o), 32'h02);
    chk("R9 comb from ch1", 32'(comb_evt_o), 1);
    wr(2'd1, 6'b111111);
    chk("R9 comb after clear", 32'(comb_evt_o), 0);
  endtask

  task automatic t_chan_out();
    chan_evt_i = 5'b01001; step();
    chk("R11 chan out", 32'(chan_evt_o), 32'h09);
    step();
    chk("R11 chan out drops", 32'(chan_evt_o), 32'h00);
  endtask

  task automatic t_ovf();
    wr(2'd1, 6'b111111);
    ovf_evt_i = 1'b1; step();
    chk("R2 ovf raw bit5", 32'(raw_o), 32'h20);
    chk("R10 ovf rise", 32'(ovf_active_o), 1);
    for (int k = 1; k < HOLD; k++) step();
    chk("R10 ovf last cycle", 32'(ovf_active_o), 1);
    step();
    chk("R10 ovf ends", 32'(ovf_active_o), 0);
    ovf_evt_i = 1'b1; step();
    for (int k = 0; k < 4; k++) step();
    ovf_evt_i = 1'b1; step();
    for (int k = 1; k < HOLD; k++) step();
    chk("R10 retrigger held", 32'(ovf_active_o), 1);
    step();
    chk("R10 retrigger ends", 32'(ovf_active_o), 0);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_events();
    t_sw_clear();
    t_sw_set();
    t_autoclr();
    t_set_wins();
    t_mask();
    t_chan_out();
    t_ovf();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule